// File: doc/BRIEF.md
# I/O Register Space Decoder

This block sits between a CPU core and a small set of peripheral registers and decodes a 64-location I/O register space. A request names a location in one of two address spaces. The port space uses 6-bit I/O numbers. The data-memory space sees the same registers shifted up by 0x20. Each request carries an operation: read, write, single-bit set, single-bit clear, or single-bit test. A response comes back one clock later. It holds the location's value as it was before the operation, the tested bit for a skip decision, and a flag that marks a bit operation as rejected.

Bit operations are allowed only on the lower half of the I/O space. A set or clear is done as a whole-byte read-modify-write. Write-one-to-clear status flags follow from that: any flag that reads as one is written back as one, so it is cleared. Peripherals raise the status flags through a flag-set input, and the control registers drive output ports.

Top module: `ioreg_decoder`

## Requirements
- R1: With acc_space=0, addresses 0x00–0x3F select I/O locations 0x00–0x3F. With acc_space=1, addresses 0x20–0x5F select I/O location (address − 0x20). Every other address selects nothing: a read returns 0x00 and a write changes no state. For example, port address 0x44 does not alias location 0x04.
- R2: The control register is at I/O 0x04 (8 bits, read/write) and drives ctrl_q. The mask register is at I/O 0x06 (bits 5:0, read/write) and drives mask_q. The config register is at I/O 0x28 (8 bits, read/write) and drives cfg_q. A write shows on the output in the cycle after the request.
- R3: Reserved bits read as zero. These are mask bits 7:6, status bits 7:4 at I/O 0x05, and high-status bits 7:2 at I/O 0x29. Unmapped locations read 0x00, and writes to them change no state.
- R4: For every request with acc_valid=1, rsp_valid is 1 in the following cycle and 0 otherwise. rsp_data holds the selected location's value from before the operation.
- R5: acc_op uses these codes: 0 read, 1 write, 2 bit set, 3 bit clear, 4 bit test. Codes 5–7 change no state and raise neither rsp_bit nor rsp_reject.
- R6: The status register at I/O 0x05 holds write-one-to-clear flags in bits 3:0. The high-status register at I/O 0x29 holds them in bits 1:0. Writing a one clears that flag, and writing a zero leaves it unchanged.
- R7: flag_set[3:0] sets status bits 3:0 and flag_set[5:4] sets high-status bits 1:0 at the next clock edge. A set in the same cycle as a clear of the same flag leaves the flag set.
- R8: A bit set or bit clear on I/O 0x00–0x1F writes back the whole byte: the read value with the bit at acc_bit (0 = LSB) forced to one or zero. On the status register, every flag written back as one is cleared.
- R9: A bit operation (codes 2–4) on a decoded I/O location 0x20–0x3F raises rsp_reject, changes no register and returns rsp_bit=0.
- R10: A bit test on I/O 0x00–0x1F returns bit acc_bit of the location on rsp_bit, in the same response cycle as rsp_data, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Request strobe |
| acc_space | input | 1 | 0 = port space, 1 = data-memory space |
| acc_addr | input | 8 | Request address |
| acc_op | input | 3 | Operation code |
| acc_bit | input | 3 | Bit index for bit operations |
| acc_wdata | input | 8 | Write data |
| flag_set | input | 6 | Peripheral flag-set pulses |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_data | output | 8 | Pre-operation read value |
| rsp_bit | output | 1 | Bit-test result |
| rsp_reject | output | 1 | Bit operation refused |
| ctrl_q | output | 8 | Control register contents |
| mask_q | output | 6 | Mask register contents |
| cfg_q | output | 8 | Config register contents |

## Verification
The hardest situation to reach is a flag-set pulse that lands in the same cycle as a clear of that flag, whether the clear comes from a plain write of ones or as a side effect of a bit set or clear that rewrites the whole status byte. Directed cases build each collision on purpose: a flag is pended, then a clear is issued while the same flag is pulsed. Seeded random traffic then drives flag-set pulses on top of mixed operations. That traffic is biased toward the two status locations in both address spaces, so collisions recur many times with different surrounding flag patterns.

// File: rtl/ioreg_pkg.sv
// Package: shared operation codes and register locations for the I/O decoder.
// Assumes an 8-bit data path and a 64-location I/O space.
package ioreg_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_BSET  = 3'd2,
        OP_BCLR  = 3'd3,
        OP_BTEST = 3'd4
    } io_op_e;

    localparam int IO_AW     = 6;
    localparam int LOC_CTRL  = 6'h04;
    localparam int LOC_STAT  = 6'h05;
    localparam int LOC_MASK  = 6'h06;
    localparam int LOC_CFG   = 6'h28;
    localparam int LOC_STATH = 6'h29;
endpackage

// File: rtl/ioreg_addr_map.sv
// Module: translates a bus address in either space into an I/O location.
// Assumes the data-memory window starts at DATA_OFS and spans the whole I/O space.
module ioreg_addr_map #(
    parameter int BUS_AW     = 8,
    parameter int IO_AW      = 6,
    parameter int DATA_OFS   = 32,
    parameter int BITOP_SPAN = 32
) (
    input  logic              space_i,
    input  logic [BUS_AW-1:0] addr_i,
    output logic [IO_AW-1:0]  loc_o,
    output logic              hit_o,
    output logic              low_o
);
    localparam int IO_SIZE = 1 << IO_AW;

    logic [BUS_AW-1:0] shifted;

    // Purpose: pick the offset for the chosen space and range-check the result.
    always_comb begin
        shifted = space_i ? (addr_i - BUS_AW'(DATA_OFS)) : addr_i;
        if (space_i)
            hit_o = (addr_i >= BUS_AW'(DATA_OFS)) && (shifted < BUS_AW'(IO_SIZE));
        else
            hit_o = (addr_i < BUS_AW'(IO_SIZE));
        loc_o = shifted[IO_AW-1:0];
        low_o = (shifted < BUS_AW'(BITOP_SPAN));
    end
endmodule

// File: rtl/ioreg_rmw.sv
// Module: turns an operation and the current byte into a write strobe and
// write byte, and gives the bit-test and reject results.
// Assumes hit/low come from the address map in the same cycle.
module ioreg_rmw
    import ioreg_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic [BW-1:0] bit_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] rd_i,
    input  logic          hit_i,
    input  logic          low_i,
    output logic          we_o,
    output logic [DW-1:0] wbyte_o,
    output logic          bit_o,
    output logic          reject_o
);
    logic [DW-1:0] sel_mask;
    logic          is_bitop;

    // Purpose: decode the operation into a whole-byte write and side results.
    always_comb begin
        sel_mask = {{(DW-1){1'b0}}, 1'b1} << bit_i;
        is_bitop = (op_i == OP_BSET) || (op_i == OP_BCLR) || (op_i == OP_BTEST);
        we_o     = 1'b0;
        wbyte_o  = wdata_i;
        bit_o    = 1'b0;
        reject_o = valid_i && hit_i && is_bitop && !low_i;
        if (valid_i && hit_i) begin
            unique case (op_i)
                OP_WRITE: we_o = 1'b1;
                OP_BSET: begin
                    we_o    = low_i;
                    wbyte_o = rd_i | sel_mask;
                end
                OP_BCLR: begin
                    we_o    = low_i;
                    wbyte_o = rd_i & ~sel_mask;
                end
                OP_BTEST: bit_o = low_i && rd_i[bit_i];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ioreg_w1c.sv
// Module: a bank of write-one-to-clear flags with peripheral set inputs.
// Assumes set_i are single-cycle pulses; a set beats a same-cycle clear.
module ioreg_w1c #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] flags_q
);
    // Purpose: clear the written ones, then apply sets so a set always wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~(clr_en_i ? clr_bits_i : '0)) | set_i;
    end

    // R7: every pulsed flag is set on the next cycle, even under a clear.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R6: a flag never rises without a set pulse.
    a_r6_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/ioreg_file.sv
// Module: the example peripheral registers and the read multiplexer.
// Assumes one write per cycle and a location already range-checked (hit_i).
module ioreg_file
    import ioreg_pkg::*;
#(
    parameter int DW     = 8,
    parameter int MASK_W = 6,
    parameter int FLO_W  = 4,
    parameter int FHI_W  = 2,
    localparam int SET_W = FLO_W + FHI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] loc_i,
    input  logic             hit_i,
    input  logic             we_i,
    input  logic [DW-1:0]    wbyte_i,
    input  logic [SET_W-1:0] set_i,
    output logic [DW-1:0]    rd_o,
    output logic [DW-1:0]    ctrl_q,
    output logic [MASK_W-1:0] mask_q,
    output logic [DW-1:0]    cfg_q
);
    logic [FLO_W-1:0] stat_q;
    logic [FHI_W-1:0] stath_q;
    logic             wr_stat;
    logic             wr_stath;

    assign wr_stat  = we_i && hit_i && (loc_i == IO_AW'(LOC_STAT));
    assign wr_stath = we_i && hit_i && (loc_i == IO_AW'(LOC_STATH));

    // Purpose: update the plain read/write registers on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (we_i && hit_i) begin
            if (loc_i == IO_AW'(LOC_CTRL)) ctrl_q <= wbyte_i;
            if (loc_i == IO_AW'(LOC_MASK)) mask_q <= wbyte_i[MASK_W-1:0];
            if (loc_i == IO_AW'(LOC_CFG))  cfg_q  <= wbyte_i;
        end
    end

    ioreg_w1c #(.W(FLO_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en_i   (wr_stat),
        .clr_bits_i (wbyte_i[FLO_W-1:0]),
        .set_i      (set_i[FLO_W-1:0]),
        .flags_q    (stat_q)
    );

    ioreg_w1c #(.W(FHI_W)) u_stath (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en_i   (wr_stath),
        .clr_bits_i (wbyte_i[FHI_W-1:0]),
        .set_i      (set_i[SET_W-1:FLO_W]),
        .flags_q    (stath_q)
    );

    // Purpose: select the addressed byte; reserved bits and holes read zero.
    always_comb begin
        rd_o = '0;
        if (hit_i) begin
            case (loc_i)
                IO_AW'(LOC_CTRL):  rd_o = ctrl_q;
                IO_AW'(LOC_STAT):  rd_o = DW'(stat_q);
                IO_AW'(LOC_MASK):  rd_o = DW'(mask_q);
                IO_AW'(LOC_CFG):   rd_o = cfg_q;
                IO_AW'(LOC_STATH): rd_o = DW'(stath_q);
                default:           rd_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/ioreg_decoder.sv
// Module: top of the I/O register space decoder. Decodes the request, performs
// the read-modify-write, and registers a one-cycle response.
// Assumes at most one request per cycle; no back-pressure.
module ioreg_decoder
    import ioreg_pkg::*;
#(
    parameter int BUS_AW     = 8,
    parameter int DW         = 8,
    parameter int DATA_OFS   = 32,
    parameter int BITOP_SPAN = 32,
    parameter int MASK_W     = 6,
    parameter int FLO_W      = 4,
    parameter int FHI_W      = 2,
    localparam int BW        = $clog2(DW),
    localparam int SET_W     = FLO_W + FHI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_space,
    input  logic [BUS_AW-1:0] acc_addr,
    input  logic [2:0]        acc_op,
    input  logic [BW-1:0]     acc_bit,
    input  logic [DW-1:0]     acc_wdata,
    input  logic [SET_W-1:0]  flag_set,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic              rsp_bit,
    output logic              rsp_reject,
    output logic [DW-1:0]     ctrl_q,
    output logic [MASK_W-1:0] mask_q,
    output logic [DW-1:0]     cfg_q
);
    logic [IO_AW-1:0] loc;
    logic             hit;
    logic             low;
    logic             we;
    logic [DW-1:0]    wbyte;
    logic [DW-1:0]    rd_byte;
    logic             bit_res;
    logic             reject;

    ioreg_addr_map #(
        .BUS_AW     (BUS_AW),
        .IO_AW      (IO_AW),
        .DATA_OFS   (DATA_OFS),
        .BITOP_SPAN (BITOP_SPAN)
    ) u_map (
        .space_i (acc_space),
        .addr_i  (acc_addr),
        .loc_o   (loc),
        .hit_o   (hit),
        .low_o   (low)
    );

    ioreg_rmw #(.DW(DW)) u_rmw (
        .valid_i  (acc_valid),
        .op_i     (acc_op),
        .bit_i    (acc_bit),
        .wdata_i  (acc_wdata),
        .rd_i     (rd_byte),
        .hit_i    (hit),
        .low_i    (low),
        .we_o     (we),
        .wbyte_o  (wbyte),
        .bit_o    (bit_res),
        .reject_o (reject)
    );

    ioreg_file #(
        .DW     (DW),
        .MASK_W (MASK_W),
        .FLO_W  (FLO_W),
        .FHI_W  (FHI_W)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .loc_i   (loc),
        .hit_i   (hit),
        .we_i    (we),
        .wbyte_i (wbyte),
        .set_i   (flag_set),
        .rd_o    (rd_byte),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q),
        .cfg_q   (cfg_q)
    );

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_bit    <= 1'b0;
            rsp_reject <= 1'b0;
        end else begin
            rsp_valid  <= acc_valid;
            rsp_data   <= acc_valid ? rd_byte : '0;
            rsp_bit    <= bit_res;
            rsp_reject <= reject;
        end
    end

    // R4: every request gets a response in the next cycle.
    a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R4: no response without a request.
    a_r4_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R9: a rejected bit operation leaves the plain registers untouched.
    a_r9_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> ($stable(ctrl_q) && $stable(mask_q) && $stable(cfg_q)));

    // R9: a rejected operation never reports a tested bit.
    a_r9_reject_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> !rsp_bit);
endmodule

// File: tb/ioreg_decoder_tb.sv
module ioreg_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_space = 1'b0;
    logic [7:0] acc_addr = '0;
    logic [2:0] acc_op = '0;
    logic [2:0] acc_bit = '0;
    logic [7:0] acc_wdata = '0;
    logic [5:0] flag_set = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_bit;
    logic       rsp_reject;
    logic [7:0] ctrl_q;
    logic [5:0] mask_q;
    logic [7:0] cfg_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    logic [7:0] m_ctrl = '0;
    logic [5:0] m_mask = '0;
    logic [7:0] m_cfg  = '0;
    logic [3:0] m_st   = '0;
    logic [1:0] m_sh   = '0;

    always #5 clk = ~clk;

    ioreg_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_space  (acc_space),
        .acc_addr   (acc_addr),
        .acc_op     (acc_op),
        .acc_bit    (acc_bit),
        .acc_wdata  (acc_wdata),
        .flag_set   (flag_set),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_bit    (rsp_bit),
        .rsp_reject (rsp_reject),
        .ctrl_q     (ctrl_q),
        .mask_q     (mask_q),
        .cfg_q      (cfg_q)
    );

    task automatic check(input string ctx, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, ctx, act, exp);
        end
    endtask

    // location decode per R1
    function automatic logic decode(input logic sp, input logic [7:0] a,
                                    output logic [5:0] loc);
        logic [7:0] s;
        s = sp ? a - 8'h20 : a;
        loc = s[5:0];
        return sp ? (a >= 8'h20 && a < 8'h60) : (a < 8'h40);
    endfunction

    // read value per R2/R3/R6
    function automatic logic [7:0] ref_read(input logic h, input logic [5:0] loc);
        if (!h) return 8'h00;
        case (loc)
            6'h04: return m_ctrl;
            6'h05: return {4'b0, m_st};
            6'h06: return {2'b0, m_mask};
            6'h28: return m_cfg;
            6'h29: return {6'b0, m_sh};
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_req(input string ctx, input logic v, input logic sp,
                          input logic [7:0] a, input logic [2:0] op,
                          input logic [2:0] b, input logic [7:0] wd,
                          input logic [5:0] fs);
        logic [5:0] loc;
        logic       h, low, we, e_bit, e_rej;
        logic [7:0] pre, wb;
        logic [3:0] clr_lo;
        logic [1:0] clr_hi;
        acc_valid = v; acc_space = sp; acc_addr = a; acc_op = op;
        acc_bit = b; acc_wdata = wd; flag_set = fs;
        h   = decode(sp, a, loc) && v;
        low = loc < 6'h20;
        pre = ref_read(h, loc);
        we = 1'b0; wb = wd; e_bit = 1'b0; e_rej = 1'b0;
        if (h) begin
            case (op)
                3'd1: we = 1'b1;
                3'd2: begin we = low; wb = pre | (8'h01 << b); end
                3'd3: begin we = low; wb = pre & ~(8'h01 << b); end
                3'd4: e_bit = low & pre[b];
                default: ;
            endcase
            e_rej = (op inside {3'd2, 3'd3, 3'd4}) && !low;
        end
        @(negedge clk);
        check(ctx, "R4", {7'b0, rsp_valid}, {7'b0, v});
        check(ctx, "R4", rsp_data, v ? pre : 8'h00);
        check(ctx, "R10", {7'b0, rsp_bit}, {7'b0, e_bit});
        check(ctx, "R9", {7'b0, rsp_reject}, {7'b0, e_rej});
        clr_lo = '0; clr_hi = '0;
        if (we) begin
            case (loc)
                6'h04: m_ctrl = wb;
                6'h06: m_mask = wb[5:0];
                6'h28: m_cfg  = wb;
                6'h05: clr_lo = wb[3:0];
                6'h29: clr_hi = wb[1:0];
                default: ;
            endcase
        end
        m_st = (m_st & ~clr_lo) | fs[3:0];
        m_sh = (m_sh & ~clr_hi) | fs[5:4];
        check(ctx, "R2", ctrl_q, m_ctrl);
        check(ctx, "R2", {2'b0, mask_q}, {2'b0, m_mask});
        check(ctx, "R2", cfg_q, m_cfg);
    endtask

    task automatic read_expect(input string ctx, input string req, input logic sp,
                               input logic [7:0] a, input logic [7:0] exp);
        do_req(ctx, 1'b1, sp, a, 3'd0, 3'd0, 8'h00, 6'h00);
        check(ctx, req, rsp_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state
        check("reset", "R4", {7'b0, rsp_valid}, 8'h00);
        check("reset", "R2", ctrl_q, 8'h00);
        check("reset", "R2", cfg_q, 8'h00);
        rst_n = 1'b1;

        // R1 R2: write through port space, read through data space
        do_req("ctrl wr", 1, 0, 8'h04, 3'd1, 0, 8'hA5, 0);
        read_expect("ctrl rd data", "R1", 1, 8'h24, 8'hA5);
        // R3: reserved mask bits read zero
        do_req("mask wr", 1, 0, 8'h06, 3'd1, 0, 8'hFF, 0);
        read_expect("mask rd", "R3", 0, 8'h06, 8'h3F);
        // R1 R2: config through data space
        do_req("cfg wr", 1, 1, 8'h48, 3'd1, 0, 8'h3C, 0);
        read_expect("cfg rd port", "R1", 0, 8'h28, 8'h3C);
        // R3 R1: holes and out-of-window addresses
        do_req("hole wr", 1, 0, 8'h10, 3'd1, 0, 8'hFF, 0);
        read_expect("hole rd", "R3", 0, 8'h10, 8'h00);
        do_req("alias wr", 1, 0, 8'h44, 3'd1, 0, 8'h00, 0);
        read_expect("no alias", "R1", 0, 8'h04, 8'hA5);
        read_expect("data below", "R1", 1, 8'h05, 8'h00);
        read_expect("data above", "R1", 1, 8'h60, 8'h00);
        // R4: idle cycle gives no response
        do_req("idle", 0, 0, 8'h04, 3'd0, 0, 8'h00, 0);
        // R7 R6
        do_req("flags on", 0, 0, 8'h00, 3'd0, 0, 8'h00, 6'h0F);
        read_expect("flags rd", "R7", 0, 8'h05, 8'h0F);
        do_req("w1c", 1, 0, 8'h05, 3'd1, 0, 8'h05, 0);
        read_expect("w1c rd", "R6", 0, 8'h05, 8'h0A);
        // R7: set collides with clear of same flag
        do_req("collide", 1, 1, 8'h25, 3'd1, 0, 8'h02, 6'h02);
        read_expect("collide rd", "R7", 0, 8'h05, 8'h0A);
        // R10: bit tests
        do_req("btest 3", 1, 0, 8'h05, 3'd4, 3'd3, 0, 0);
        check("btest 3", "R10", {7'b0, rsp_bit}, 8'h01);
        do_req("btest 2", 1, 0, 8'h05, 3'd4, 3'd2, 0, 0);
        check("btest 2", "R10", {7'b0, rsp_bit}, 8'h00);
        // R8: bit clear on status clears the other set flags
        do_req("bclr st", 1, 0, 8'h05, 3'd3, 3'd3, 0, 0);
        read_expect("bclr st rd", "R8", 0, 8'h05, 8'h08);
        do_req("bset ctrl", 1, 0, 8'h04, 3'd2, 3'd1, 0, 0);
        read_expect("bset ctrl rd", "R8", 0, 8'h04, 8'hA7);
        // R9: bit operations above 0x1F
        do_req("bset cfg", 1, 0, 8'h28, 3'd2, 3'd0, 0, 0);
        check("bset cfg", "R9", {7'b0, rsp_reject}, 8'h01);
        read_expect("bset cfg rd", "R9", 0, 8'h28, 8'h3C);
        do_req("sh on", 0, 0, 0, 0, 0, 0, 6'h10);
        do_req("btest sh", 1, 1, 8'h49, 3'd4, 3'd0, 0, 0);
        check("btest sh", "R9", {7'b0, rsp_bit}, 8'h00);
        // R5: unused op codes
        do_req("op5", 1, 0, 8'h04, 3'd5, 3'd0, 8'h00, 0);
        do_req("op7", 1, 0, 8'h05, 3'd7, 3'd3, 8'hFF, 0);
        read_expect("op rd", "R5", 0, 8'h05, 8'h08);

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic       sp;
            int         pick;
            sp   = 1'($urandom);
            pick = $urandom_range(0, 9);
            case (pick)
                0: a = 8'h04;
                1, 2: a = 8'h05;
                3: a = 8'h06;
                4: a = 8'h28;
                5, 6: a = 8'h29;
                default: a = 8'($urandom);
            endcase
            if (sp && pick < 7) a = a + 8'h20;
            do_req("random", ($urandom_range(0, 7) != 0), sp, a,
                   3'($urandom), 3'($urandom), 8'($urandom),
                   ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule